// File: doc/BRIEF.md
# 32-Pin GPIO Controller with Interrupt Detection

This block is a general-purpose I/O peripheral for 32 pins. A simple register bus carries an address, a write enable, write data and read data. Through it, software sets the levels driven on the pads and the output enable of each pin. Software can also read back the pad levels after they pass through a synchronizer. The pad side is three plain vectors: pad input, pad output and pad output enable.

Each pin watches its synchronized level for an interrupt condition that software selects: low level, high level, rising edge or falling edge. A per-pin any-edge override replaces the selected condition with detection of both edges. A detected condition sets a sticky status bit, and software clears it by writing 1 to that bit. Masked status drives two combined interrupt lines, one for pins 0 to 15 and one for pins 16 to 31. It also drives eight dedicated lines for pins 0 to 7.

Top module: `gpio_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0, and `pad_o`, `pad_oe_o` and all interrupt outputs are 0.
- R2: Register 0x00 holds the output data. Its value drives `pad_o` from the clock edge that writes it, and it reads back unchanged.
- R3: Register 0x04 holds the direction. A bit of 1 sets the matching `pad_oe_o` bit, making the pin an output, and a bit of 0 makes the pin an input. The register reads back unchanged.
- R4: Register 0x08 returns `pad_i` through two flops. A pad change is not visible after one rising clock edge and is visible after the second.
- R5: Register 0x0C holds the 2-bit condition fields for pins 0 to 15, and register 0x10 holds them for pins 16 to 31. Pin n uses bits [2(n mod 16)+1 : 2(n mod 16)]. The codes are 0 for low level, 1 for high level, 2 for rising edge and 3 for falling edge.
- R6: A level condition sets the pin's status bit on every cycle in which the level holds, so clearing the bit does not take effect while the level persists.
- R7: An edge condition sets status once for an edge in the selected direction, and an edge in the other direction has no effect.
- R8: Register 0x1C is the any-edge select. When a pin's bit is 1, its condition code is ignored and both rising and falling edges set its status bit.
- R9: Register 0x18 returns status. Writing it clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: If a clear write and a new detection hit the same status bit in the same cycle, the bit remains set.
- R11: Register 0x14 is the mask. `irq_lo_o` is the OR of status AND mask over pins 0 to 15, and `irq_hi_o` is the same over pins 16 to 31.
- R12: `irq_pin_o[k]`, for k from 0 to 7, equals status AND mask of pin k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Byte address. An access hits a register only when bits [1:0] are 0. |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pad_i | input | 32 | Pad input levels, asynchronous |
| pad_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables |
| irq_lo_o | output | 1 | Combined interrupt for pins 0 to 15 |
| irq_hi_o | output | 1 | Combined interrupt for pins 16 to 31 |
| irq_pin_o | output | 8 | Dedicated interrupts for pins 0 to 7 |

## Verification
The hardest case to reach from the ports is a clear write that lands in the exact cycle in which a synchronized edge is detected. The bench changes a pad just after a falling clock edge and counts the two synchronizer stages. It then raises the write enable for the status register so that the write is sampled at the same rising edge that latches the detection, and checks that the bit survives. A second hard case is a level condition that keeps re-setting status. The bench checks it by clearing a bit while the level still holds and reading the status back after further cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PINS     = 32;
  localparam int unsigned DED_IRQS = 8;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned SYNC_STG = 2;

  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_EDGE   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } cond_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      lvl_i,
  input  logic [N-1:0][1:0] cfg_i,
  input  logic [N-1:0]      any_edge_i,
  input  logic [N-1:0]      clr_i,
  output logic [N-1:0]      status_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] hit;
  logic [N-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      if (any_edge_i[i]) begin
        hit[i] = lvl_i[i] ^ prev_q[i];
      end else begin
        unique case (cond_e'(cfg_i[i]))
          COND_LOW:  hit[i] = ~lvl_i[i];
          COND_HIGH: hit[i] = lvl_i[i];
          COND_RISE: hit[i] = lvl_i[i] & ~prev_q[i];
          COND_FALL: hit[i] = ~lvl_i[i] & prev_q[i];
          default:   hit[i] = 1'b0;
        endcase
      end
    end
  end

  // new detection takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit;
  end

  assign status_o = stat_q;

  a_r9_clear_takes_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr_i & ~hit)) == '0));

  a_r10_detect_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit) & ~stat_q) == '0));

  a_r7_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out #(
  parameter int unsigned N   = 32,
  parameter int unsigned DED = 8
) (
  input  logic [N-1:0]   status_i,
  input  logic [N-1:0]   mask_i,
  output logic           irq_lo_o,
  output logic           irq_hi_o,
  output logic [DED-1:0] irq_ded_o
);
  localparam int unsigned HALF = N / 2;

  logic [N-1:0] masked;

  assign masked    = status_i & mask_i;
  assign irq_lo_o  = |masked[HALF-1:0];
  assign irq_hi_o  = |masked[N-1:HALF];
  assign irq_ded_o = masked[DED-1:0];
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N     = PINS,
  parameter int unsigned DED   = DED_IRQS,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [N-1:0]  pad_i,
  output logic [N-1:0]  pad_o,
  output logic [N-1:0]  pad_oe_o,
  output logic          irq_lo_o,
  output logic          irq_hi_o,
  output logic [DED-1:0] irq_pin_o
);
  localparam int unsigned HALF = N / 2;

  reg_sel_e sel;
  logic     hit_reg;
  logic     wr;

  logic [N-1:0]  data_q, dir_q, mask_q, edge_q;
  logic [31:0]   cfg_lo_q, cfg_hi_q;
  logic [N-1:0]  lvl, status, clr;
  logic [N-1:0][1:0] cfg_all;

  assign sel     = reg_sel_e'(addr_i[AW-1:2]);
  assign hit_reg = (addr_i[1:0] == 2'b00);
  assign wr      = we_i & hit_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      mask_q   <= '0;
      edge_q   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
    end else if (wr) begin
      unique case (sel)
        REG_DATA:   data_q   <= wdata_i[N-1:0];
        REG_DIR:    dir_q    <= wdata_i[N-1:0];
        REG_CFG_LO: cfg_lo_q <= wdata_i;
        REG_CFG_HI: cfg_hi_q <= wdata_i;
        REG_MASK:   mask_q   <= wdata_i[N-1:0];
        REG_EDGE:   edge_q   <= wdata_i[N-1:0];
        default: ;
      endcase
    end
  end

  assign clr     = (wr && sel == REG_STAT) ? wdata_i[N-1:0] : '0;
  assign cfg_all = {cfg_hi_q, cfg_lo_q};

  gpio_sync #(.W(N), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (lvl)
  );

  gpio_detect #(.N(N)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .cfg_i     (cfg_all),
    .any_edge_i(edge_q),
    .clr_i     (clr),
    .status_o  (status)
  );

  gpio_irq_out #(.N(N), .DED(DED)) u_irq (
    .status_i (status),
    .mask_i   (mask_q),
    .irq_lo_o (irq_lo_o),
    .irq_hi_o (irq_hi_o),
    .irq_ded_o(irq_pin_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_reg) begin
      unique case (sel)
        REG_DATA:   rdata_o = data_q;
        REG_DIR:    rdata_o = dir_q;
        REG_PAD:    rdata_o = lvl;
        REG_CFG_LO: rdata_o = cfg_lo_q;
        REG_CFG_HI: rdata_o = cfg_hi_q;
        REG_MASK:   rdata_o = mask_q;
        REG_STAT:   rdata_o = status;
        REG_EDGE:   rdata_o = edge_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign pad_o    = data_q;
  assign pad_oe_o = dir_q;

  a_r2_data_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h00) |=> (pad_o == $past(wdata_i)));

  a_r3_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h04) |=> (pad_oe_o == $past(wdata_i)));

  a_r11_lo_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> (mask_q[HALF-1:0] != '0));

  a_r12_ded_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pin_o != '0) |-> ((status[DED-1:0] & irq_pin_o) == irq_pin_o));
endmodule

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pad_i = '0;
  logic [31:0] pad_o, pad_oe_o;
  logic        irq_lo_o, irq_hi_o;
  logic [7:0]  irq_pin_o;

  gpio_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o),
    .irq_pin_o(irq_pin_o)
  );

  always #10 clk_i = ~clk_i;

  localparam int SEL_REG = 0, SEL_IRQ = 1, SEL_PO = 2, SEL_OE = 3;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;

  // monitor: compares each pending expectation shortly after it is queued
  initial begin
    forever begin
      wait (sb.size() != 0);
      #2;
      begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          SEL_REG: act = rdata_o;
          SEL_IRQ: act = {22'd0, irq_pin_o, irq_hi_o, irq_lo_o};
          SEL_PO:  act = pad_o;
          default: act = pad_oe_o;
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(input int sel, input logic [4:0] a,
                            input logic [31:0] e, input string tag);
    item_t it;
    addr_i = a;
    it.sel = sel; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  // expected interrupt vector {pin[7:0], hi, lo} from status and mask
  function automatic logic [31:0] irq_exp(input logic [31:0] st, input logic [31:0] mk);
    logic [31:0] m;
    m = st & mk;
    return {22'd0, m[7:0], |m[31:16], |m[15:0]};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R1 reset values
    expect_val(SEL_REG, 5'h00, 32'h0, "R1 data");
    expect_val(SEL_REG, 5'h04, 32'h0, "R1 dir");
    expect_val(SEL_REG, 5'h18, 32'h0, "R1 status");
    expect_val(SEL_REG, 5'h14, 32'h0, "R1 mask");
    expect_val(SEL_OE,  5'h00, 32'h0, "R1 pad_oe");
    expect_val(SEL_IRQ, 5'h00, 32'h0, "R1 irq");
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(3);
    // R6 default code 0 is low level, pads low -> all status set
    expect_val(SEL_REG, 5'h18, 32'hFFFF_FFFF, "R6 default low level");

    // R2 / R3
    wr(5'h00, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000);
    expect_val(SEL_PO,  5'h00, 32'hA5A5_0F0F, "R2 pad_o");
    expect_val(SEL_REG, 5'h00, 32'hA5A5_0F0F, "R2 readback");
    expect_val(SEL_OE,  5'h00, 32'hFFFF_0000, "R3 pad_oe");
    expect_val(SEL_REG, 5'h04, 32'hFFFF_0000, "R3 readback");

    // R4 two-flop synchronizer
    @(negedge clk_i);
    pad_i = 32'h1234_5678;
    tick(1);
    expect_val(SEL_REG, 5'h08, 32'h0, "R4 one edge");
    tick(1);
    expect_val(SEL_REG, 5'h08, 32'h1234_5678, "R4 two edges");
    pad_i = 32'h0;
    tick(4);

    // R5 conditions: p0 rise, p1 fall, p2 high, p3 low, p17 rise, rest high
    wr(5'h0C, 32'h5555_551E);
    wr(5'h10, 32'h5555_5559);
    expect_val(SEL_REG, 5'h0C, 32'h5555_551E, "R5 cfg lo readback");
    expect_val(SEL_REG, 5'h10, 32'h5555_5559, "R5 cfg hi readback");
    tick(2);
    wr(5'h18, 32'hFFFF_FFFF);
    tick(3);
    expect_val(SEL_REG, 5'h18, 32'h0000_0008, "R6 low level persists");

    // R7 rising on pin0
    pad_i[0] = 1'b1; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0000_0009, "R7 rise sets");
    wr(5'h18, 32'h1);
    pad_i[0] = 1'b0; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0000_0008, "R7 fall ignored on rise pin");
    // R7 falling on pin1
    pad_i[1] = 1'b1; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0000_0008, "R7 rise ignored on fall pin");
    pad_i[1] = 1'b0; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0000_000A, "R7 fall sets");

    // R9 partial write-one-to-clear
    pad_i[0] = 1'b1; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0000_000B, "R9 before clear");
    wr(5'h18, 32'h1);
    expect_val(SEL_REG, 5'h18, 32'h0000_000A, "R9 zero bits kept");

    // R6 high level on pin2 survives clear
    pad_i[2] = 1'b1; tick(4);
    wr(5'h18, 32'h4);
    tick(2);
    expect_val(SEL_REG, 5'h18, 32'h0000_000E, "R6 high level persists");
    pad_i[2] = 1'b0; tick(4);
    wr(5'h18, 32'h4);
    expect_val(SEL_REG, 5'h18, 32'h0000_000A, "R6 clear after level drops");

    // R5 high register field: pin17 rising
    pad_i[17] = 1'b1; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0002_000A, "R5 pin17 field");

    // R8 any-edge on pin20 (code high, so falling proves override)
    wr(5'h1C, 32'h0010_0000);
    expect_val(SEL_REG, 5'h1C, 32'h0010_0000, "R8 readback");
    pad_i[20] = 1'b1; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0012_000A, "R8 rise");
    wr(5'h18, 32'h0010_0000);
    expect_val(SEL_REG, 5'h18, 32'h0002_000A, "R8 cleared");
    pad_i[20] = 1'b0; tick(4);
    expect_val(SEL_REG, 5'h18, 32'h0012_000A, "R8 fall");

    // R11 / R12 masking
    expect_val(SEL_IRQ, 5'h00, 32'h0, "R11 mask zero");
    wr(5'h14, 32'h0010_0000);
    expect_val(SEL_IRQ, 5'h00, irq_exp(32'h0012_000A, 32'h0010_0000), "R11 hi only");
    wr(5'h14, 32'h0000_000A);
    expect_val(SEL_IRQ, 5'h00, irq_exp(32'h0012_000A, 32'h0000_000A), "R12 pins 1 and 3");
    wr(5'h14, 32'h0010_0008);
    expect_val(SEL_IRQ, 5'h00, irq_exp(32'h0012_000A, 32'h0010_0008), "R11 both lines");
    wr(5'h14, 32'h0000_FFF0);
    expect_val(SEL_IRQ, 5'h00, 32'h0, "R11 masked-off status");

    // R10 clear colliding with detection on pin0
    pad_i[0] = 1'b0; tick(4);
    wr(5'h18, 32'hFFFF_FFFF);
    tick(1);
    expect_val(SEL_REG, 5'h18, 32'h0000_0008, "R10 setup");
    @(negedge clk_i);
    pad_i[0] = 1'b1;
    tick(2);
    addr_i = 5'h18; wdata_i = 32'h1; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    expect_val(SEL_REG, 5'h18, 32'h0000_0009, "R10 detect wins");
    wr(5'h18, 32'h1);
    expect_val(SEL_REG, 5'h18, 32'h0000_0008, "R10 later clear works");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule